// File: doc/BRIEF.md
# Ingress Color Tagging and Drain Sequencer

This block sits at the output of an ingress adapter that feeds one plane of a two-plane switch fabric. It chooses the next cell for the link and sets the color bit in that cell's qualifier byte. The enqueue side reads its current color from `enq_color` and stamps that color into each cell as the cell is queued. The block never rewrites that color later, so a queued cell keeps the color it was given.

Software starts a switchover with a one-cycle command. The command carries a role for this plane and the new color.

- **Idle role.** The plane is being dropped. The adapter stops taking cells from its queues and fills the link with idle cells in the new color.
- **Active role.** The plane keeps carrying traffic. Every queue head whose color differs from the current color is an old-color cell.
  - While any old-color cell remains, the priority scheduler is bypassed. Old-color cells leave in arrival order, whatever their priority.
  - Once none remains, strict-priority service of new-color cells resumes.

The queues are outside this block. It sees only each queue's head (valid, color, arrival stamp, payload) and returns a pop strobe. The link accepts a cell in any cycle where `link_rdy` is high; otherwise the presented cell is held.

Top module: `ingress_color_drain`

## Requirements
- R1: While `rst_n` is low, `out_vld` is 0 and `enq_color` equals the reset color (0 by default). With all queues empty, `drain_done` is 1.
- R2: A cycle with `cmd_valid` high sets `enq_color` to `cmd_color` from the next cycle on. The role (`cmd_idle_role`=1 for idle, 0 for active) takes effect for every cell loaded after that edge. The reset role is active.
- R3: In the active role with no old-color cell present, data cells are served by strict priority, with queue 0 the highest. Each data cell leaves with the color its queue entry recorded at enqueue.
- R4: In the active role, while any valid queue head has a color different from `enq_color`, only old-color cells are sent. They are taken in ascending order of arrival stamp, regardless of priority, with ties going to the lower queue index. No new-color data cell leaves before the last old-color cell.
- R5: `drain_done` is 1 exactly when no valid queue head carries a color different from `enq_color`.
- R6: In the idle role, no queue is popped. Every cell loaded onto the link is an idle cell (`out_idle`=1) whose color is `enq_color`.
- R7: When no data cell is eligible, an idle cell is loaded with `out_idle`=1 and color `enq_color`.
- R8: While `out_vld` is 1 and `link_rdy` is 0, `out_cell`, `out_color` and `out_idle` hold their values and no queue is popped.
- R9: `q_pop` has at most one bit set. A bit is set only for a valid queue, and only in the cycle that queue's head is loaded into the output register. Each data cell leaves exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Switchover command strobe |
| cmd_idle_role | input | 1 | 1: this plane is idled, 0: this plane stays active |
| cmd_color | input | 1 | New color carried by the command |
| q_valid | input | NPRIO | Queue head present, one bit per priority |
| q_color | input | NPRIO | Color recorded in each queue head |
| q_stamp | input | NPRIO*STAMP_W | Arrival stamp of each queue head |
| q_data | input | NPRIO*CELL_W | Payload of each queue head |
| q_pop | output | NPRIO | Head of this queue is taken this cycle |
| link_rdy | input | 1 | Link accepts the presented cell |
| out_vld | output | 1 | A cell is presented |
| out_cell | output | CELL_W | Presented payload (0 for idle cells) |
| out_color | output | 1 | Qualifier color bit of the presented cell |
| out_idle | output | 1 | Presented cell is an idle cell |
| out_prio | output | PW | Queue the presented data cell came from |
| enq_color | output | 1 | Color to stamp into newly queued cells |
| drain_done | output | 1 | No old-color cell remains at any queue head |

## Verification
The bench uses the defaults: four priorities, 8-bit payloads and 8-bit arrival stamps. Four queues are enough to set up stamp orders that run against priority order, which separates draining by arrival from strict-priority service. The narrow payload lets every cell carry a unique identifier, so each cell's order of departure and its color can be checked one by one. The same queue contents are reused across an idle-role command and a later active-role command of the opposite color. This drains cells whose recorded color is the one the earlier switchover had introduced.

// File: rtl/ingress_color_drain.sv
module ingress_color_drain #(
  parameter int NPRIO = 4,
  parameter int CELL_W = 8,
  parameter int STAMP_W = 8,
  parameter bit RST_COLOR = 1'b0,
  localparam int PW = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic                      cmd_idle_role,
  input  logic                      cmd_color,
  input  logic [NPRIO-1:0]          q_valid,
  input  logic [NPRIO-1:0]          q_color,
  input  logic [NPRIO*STAMP_W-1:0]  q_stamp,
  input  logic [NPRIO*CELL_W-1:0]   q_data,
  output logic [NPRIO-1:0]          q_pop,
  input  logic                      link_rdy,
  output logic                      out_vld,
  output logic [CELL_W-1:0]         out_cell,
  output logic                      out_color,
  output logic                      out_idle,
  output logic [PW-1:0]             out_prio,
  output logic                      enq_color,
  output logic                      drain_done
);

  logic             col_q, idle_role_q;
  logic [NPRIO-1:0] old_mask;
  logic [PW-1:0]    old_sel, pri_sel, sel;
  logic             load, send_data;

  assign enq_color  = col_q;
  assign old_mask   = q_valid & (q_color ^ {NPRIO{col_q}});
  assign drain_done = ~|old_mask;

  always_comb begin
    logic             found;
    logic [STAMP_W-1:0] best;
    found   = 1'b0;
    best    = '0;
    old_sel = '0;
    for (int i = 0; i < NPRIO; i++) begin
      if (old_mask[i] && (!found || q_stamp[i*STAMP_W +: STAMP_W] < best)) begin
        found   = 1'b1;
        best    = q_stamp[i*STAMP_W +: STAMP_W];
        old_sel = PW'(i);
      end
    end
  end

  always_comb begin
    pri_sel = '0;
    for (int i = NPRIO-1; i >= 0; i--)
      if (q_valid[i]) pri_sel = PW'(i);
  end

  assign sel       = drain_done ? pri_sel : old_sel;
  assign load      = !out_vld || link_rdy;
  assign send_data = !idle_role_q && |q_valid;
  assign q_pop     = (load && send_data) ? (NPRIO'(1) << sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q       <= RST_COLOR;
      idle_role_q <= 1'b0;
      out_vld     <= 1'b0;
      out_cell    <= '0;
      out_color   <= RST_COLOR;
      out_idle    <= 1'b1;
      out_prio    <= '0;
    end else begin
      if (cmd_valid) begin
        col_q       <= cmd_color;
        idle_role_q <= cmd_idle_role;
      end
      if (load) begin
        out_vld   <= 1'b1;
        out_idle  <= !send_data;
        out_cell  <= send_data ? q_data[sel*CELL_W +: CELL_W] : '0;
        out_color <= send_data ? q_color[sel] : col_q;
        out_prio  <= send_data ? sel : '0;
      end
    end
  end

endmodule

// File: rtl/ingress_color_drain_chk.sv
module ingress_color_drain_chk #(
  parameter int NPRIO = 4,
  parameter int CELL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_color,
  input logic [NPRIO-1:0]  q_valid,
  input logic [NPRIO-1:0]  q_color,
  input logic [NPRIO-1:0]  q_pop,
  input logic              link_rdy,
  input logic              out_vld,
  input logic [CELL_W-1:0] out_cell,
  input logic              out_color,
  input logic              out_idle,
  input logic              enq_color,
  input logic              drain_done,
  input logic              idle_role_q
);

  logic [NPRIO-1:0] new_heads;
  assign new_heads = q_valid & ~(q_color ^ {NPRIO{enq_color}});

  a_r2_cmd_color: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> enq_color == $past(cmd_color));

  a_r4_old_first: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_done |-> (q_pop & new_heads) == '0);

  a_r6_idle_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    idle_role_q |-> q_pop == '0);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !link_rdy) |=> (out_vld && $stable(out_cell) && $stable(out_color) && $stable(out_idle)));

  a_r8_no_pop_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !link_rdy) |-> q_pop == '0);

  a_r9_pop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_pop) && ((q_pop & ~q_valid) == '0));

endmodule

bind ingress_color_drain ingress_color_drain_chk #(.NPRIO(NPRIO), .CELL_W(CELL_W)) u_chk (.*);

// File: tb/test_ingress_color_drain.sv
module test_ingress_color_drain;
  localparam int NP = 4, CW = 8, SW = 8, PW = 2;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_idle_role = 0, cmd_color = 0, link_rdy = 0;
  logic [NP-1:0] q_valid, q_color, q_pop;
  logic [NP*SW-1:0] q_stamp;
  logic [NP*CW-1:0] q_data;
  logic out_vld, out_color, out_idle, enq_color, drain_done;
  logic [CW-1:0] out_cell;
  logic [PW-1:0] out_prio;

  always #10 clk = ~clk;

  ingress_color_drain i_ingress_color_drain (.*);

  logic [7:0] qd [NP][16];
  logic       qc [NP][16];
  logic [7:0] qs [NP][16];
  int hd [NP], tl [NP];
  int next_id = 1, stamp = 0;
  logic [NP-1:0] pend = '0;

  logic [7:0] lg_d [512];
  logic       lg_c [512];
  logic       lg_i [512];
  int n = 0, checks = 0, fails = 0;

  initial for (int i = 0; i < NP; i++) begin hd[i] = 0; tl[i] = 0; end

  always_comb
    for (int i = 0; i < NP; i++) begin
      q_valid[i] = hd[i] != tl[i];
      q_color[i] = qc[i][hd[i] % 16];
      q_data[i*CW +: CW] = qd[i][hd[i] % 16];
      q_stamp[i*SW +: SW] = qs[i][hd[i] % 16];
    end

  always @(negedge clk) begin
    pend = q_pop;
    if (rst_n && out_vld && link_rdy) begin
      lg_d[n] = out_cell; lg_c[n] = out_color; lg_i[n] = out_idle; n++;
    end
  end

  always @(posedge clk) begin
    #1;
    for (int i = 0; i < NP; i++) if (pend[i]) hd[i]++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int p, input bit col);
    qd[p][tl[p] % 16] = 8'(next_id);
    qc[p][tl[p] % 16] = col;
    qs[p][tl[p] % 16] = 8'(stamp);
    tl[p]++; next_id++; stamp++;
  endtask

  task automatic cyc(input int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  task automatic command(input bit idle_role, input bit col);
    cmd_valid = 1; cmd_idle_role = idle_role; cmd_color = col;
    cyc(1);
    cmd_valid = 0;
  endtask

  // compare data cells logged since n0 with expected ids and colors
  task automatic expect_data(input int n0, input string req, input int ids[$], input bit cols[$]);
    int k = 0;
    for (int j = n0; j < n; j++) begin
      if (!lg_i[j]) begin
        if (k < ids.size()) begin
          chk(lg_d[j] == 8'(ids[k]), req, "data order", lg_d[j], ids[k]);
          chk(lg_c[j] == cols[k], req, "data color", lg_c[j], cols[k]);
        end
        k++;
      end
    end
    chk(k == ids.size(), req, "data cell count", k, ids.size());
  endtask

  task automatic t_reset;
    cyc(3);
    @(negedge clk);
    chk(out_vld == 0, "R1", "out_vld in reset", out_vld, 0);
    chk(enq_color == 0, "R1", "enq_color in reset", enq_color, 0);
    chk(drain_done == 1, "R1", "drain_done in reset", drain_done, 1);
    cyc(1);
    rst_n = 1;
    cyc(2);
  endtask

  task automatic t_priority;
    int n0;
    link_rdy = 0;
    push(3, 0); push(1, 0); push(2, 0); push(0, 0);
    cyc(1);
    n0 = n;
    link_rdy = 1;
    cyc(10);
    expect_data(n0, "R3", '{4, 2, 3, 1}, '{0, 0, 0, 0});
    chk(lg_i[n-1] && lg_c[n-1] == 0, "R7", "idle filler color 0", lg_c[n-1], 0);
    for (int i = 0; i < NP; i++)
      chk(hd[i] == tl[i], "R9", "queue emptied once", tl[i] - hd[i], 0);
  endtask

  task automatic t_stall;
    int n0;
    logic [7:0] c0;
    logic o0;
    link_rdy = 0;
    push(2, 0);
    cyc(1);
    @(negedge clk);
    n0 = n; c0 = out_cell; o0 = out_idle;
    cyc(5);
    @(negedge clk);
    chk(n == n0, "R8", "no transfer while stalled", n, n0);
    chk(out_cell == c0 && out_idle == o0, "R8", "output held", out_cell, c0);
    chk(tl[2] - hd[2] == 1, "R8", "no pop while stalled", tl[2] - hd[2], 1);
    cyc(1);
    link_rdy = 1;
    cyc(4);
    expect_data(n0, "R8", '{5}, '{0});
  endtask

  task automatic t_drain;
    int n0;
    link_rdy = 0;
    push(3, 0); push(1, 0); push(0, 0);
    cyc(1);
    command(0, 1);
    push(0, 1); push(1, 1);
    @(negedge clk);
    chk(enq_color == 1, "R2", "enq_color after command", enq_color, 1);
    chk(drain_done == 0, "R5", "drain_done with old heads", drain_done, 0);
    n0 = n;
    cyc(1);
    link_rdy = 1;
    cyc(12);
    expect_data(n0, "R4", '{6, 7, 8, 9, 10}, '{0, 0, 0, 1, 1});
    @(negedge clk);
    chk(drain_done == 1, "R5", "drain_done after drain", drain_done, 1);
    chk(lg_i[n-1] && lg_c[n-1] == 1, "R7", "idle filler new color", lg_c[n-1], 1);
  endtask

  task automatic t_idle_role;
    int n0;
    link_rdy = 0;
    push(2, 1); push(0, 1);
    cyc(1);
    command(1, 0);
    @(negedge clk);
    chk(drain_done == 0, "R5", "old heads after idle command", drain_done, 0);
    cyc(1);
    link_rdy = 1;
    cyc(2);
    n0 = n;
    cyc(8);
    for (int j = n0; j < n; j++)
      chk(lg_i[j] && lg_c[j] == 0, "R6", "idle cell new color", {lg_i[j], lg_c[j]}, 2);
    chk(n - n0 >= 7, "R6", "idle cells keep flowing", n - n0, 8);
    chk(tl[2] - hd[2] == 1 && tl[0] - hd[0] == 1, "R6", "queues untouched", tl[0] - hd[0], 1);
  endtask

  task automatic t_resume;
    int n0;
    link_rdy = 0;
    cyc(1);
    n0 = n;
    command(0, 0);
    link_rdy = 1;
    cyc(8);
    expect_data(n0, "R4", '{11, 12}, '{1, 1});
    @(negedge clk);
    chk(drain_done == 1, "R5", "drain_done after resume", drain_done, 1);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_priority;
        t_stall;
        t_drain;
        t_idle_role;
        t_resume;
      end
      begin
        repeat (20000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 1, 0);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule